// File: doc/BRIEF.md
# Serial Control Register Block for a Six-Channel Audio Output Stage

This block takes a write-only, three-wire serial control stream (serial clock, mode line, data line) and holds the configuration of a six-channel audio output stage. All three lines are resynchronised into the system clock domain. A bit is taken on each rising edge of the serial clock, least significant bit first. A byte sent while the mode line is low is an address byte: it selects the device and one of two register banks. Bytes sent while the mode line is high are data bytes for the selected bank. Each data byte takes effect once its eighth bit has arrived.

The status bank holds the global settings: clock ratio, input format, mute type, power, and a self-clearing reset command. The data bank holds one register set per channel: volume, sub volume, mute, silence-detection participation and polarity. It also holds a global de-emphasis field. A channel pointer, which holds its value until rewritten, chooses one channel for each write, or a broadcast bit sends the write to all six. A sub-volume write is held pending and only takes effect at the next volume write to that channel. All register contents appear on the outputs as decoded fields.

Top module: `ctl3w_regs`

## Requirements
- R1: An address byte is eight bits sent with the mode line low. Its bits 7:2 are the device code and its bits 1:0 are the bank type. The device code must be 000100, or 000101 while `addr_sel_i` is high. Bank type 00 selects the data bank and 10 selects the status bank.
- R2: An address byte with any other device code deselects the block, and every later data byte is ignored until a matching address byte arrives.
- R3: Once a device code and bank match, they stay selected for any number of data bytes.
- R4: A byte is committed only after its eighth bit. A change on the mode line throws away a partly received byte, and the next bit starts a new byte.
- R5: A status byte with bit 7 = 0 loads the clock ratio from bits 5:4 and the input format from bits 3:1.
- R6: A status byte with bits 7:2 = 100000 loads the mute type from bit 1 (1 = quick) and power from bit 0 (1 = on).
- R7: A data byte with bits 7:6 = 00 loads the 6-bit volume (bits 5:0) into the targeted channels. Channel k appears at `vol_o[6k+5:6k]`.
- R8: A data byte with bits 7:4 = 1100 loads the broadcast bit from bit 3 and the channel pointer from bits 2:0. Pointer codes 000 to 101 select channels 0 to 5. When the broadcast bit is 1, every channel is targeted.
- R9: With broadcast off, pointer codes 110 and 111 target no channel. Bank types 01 and 11 select nothing. Writes in either case change no register.
- R10: A data byte with bits 7:6 = 10 loads mute (bit 2), silence participation (bit 1) and inversion (bit 0) into the targeted channels. It loads de-emphasis from bits 5:3 only when broadcast is on.
- R11: A data byte with bits 7:2 = 010000 stores a pending 2-bit sub volume (bits 1:0) for the targeted channels. The value reaches `sub_vol_o` (channel k at bits 2k+1:2k) only when a later volume write targets that channel.
- R12: A status byte with bit 7 = 0 and bit 6 = 1 restores the defaults of all fields except clock ratio and input format. The defaults are: soft mute type, power on, volume 0, sub volume 0 (active and pending), de-emphasis 0, mute 0, participation 1, and inversion 0. The clock ratio and input format still load from the same byte.
- R13: After `rst_ni`, all fields hold the R12 defaults, with clock ratio 00, input format 000, broadcast on and the channel pointer at 000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Serial control clock (asynchronous) |
| ser_mode_i | input | 1 | Mode line: low = address, high = data |
| ser_dat_i | input | 1 | Serial data, LSB first |
| addr_sel_i | input | 1 | Device code select (sets code bit 0) |
| clk_ratio_o | output | 2 | System clock ratio field |
| in_fmt_o | output | 3 | Input format field |
| quick_mute_o | output | 1 | 1 = quick mute, 0 = soft mute |
| power_on_o | output | 1 | Power enable |
| deemph_o | output | 3 | De-emphasis selection |
| vol_o | output | 36 | Per-channel volume, 6 bits each |
| sub_vol_o | output | 12 | Per-channel active sub volume, 2 bits each |
| mute_o | output | 6 | Per-channel mute |
| sil_en_o | output | 6 | Per-channel silence-detection participation |
| invert_o | output | 6 | Per-channel output inversion |

## Verification
Some properties are checked by assertions on every cycle:
- byte-valid pulses are never back to back;
- the bit counter holds still without a serial clock edge;
- an active sub volume changes only on a volume write or a reset command;
- no field moves while the block is deselected or while the pointer holds an unused code;
- the clock ratio follows the reset command byte.

Other behaviour only the bench scenarios can show:
- the actual field values after a full byte sequence;
- the order dependence of sub volume and volume;
- throwing away a byte cut short by the mode line;
- the effect of the address-select pin on which device code matches.

// File: rtl/ctl3w_pkg.sv
package ctl3w_pkg;
  localparam int NCH   = 6;
  localparam int VOL_W = 6;
  localparam int SUB_W = 2;
  localparam int CH_W  = $clog2(NCH);
  localparam logic [5:0] DEV_BASE = 6'b000100;

  typedef struct packed {
    logic [VOL_W-1:0] vol;
    logic [SUB_W-1:0] sub;
    logic             mute;
    logic             sil;
    logic             inv;
  } chan_t;
endpackage

// File: rtl/ctl3w_sync.sv
module ctl3w_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) st_q[i] <= '0;
    end else begin
      st_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) st_q[i] <= st_q[i-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/ctl3w_rx.sv
module ctl3w_rx (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sclk_i,
  input  logic       mode_i,
  input  logic       dat_i,
  output logic       byte_vld_o,
  output logic [7:0] byte_o,
  output logic       addr_phase_o
);
  logic       sclk_d, mode_d;
  logic [2:0] cnt_q;
  logic [7:0] sr_q;
  logic       rise, mode_chg;

  assign rise     = sclk_i & ~sclk_d;
  assign mode_chg = mode_i ^ mode_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_d       <= 1'b0;
      mode_d       <= 1'b0;
      cnt_q        <= '0;
      sr_q         <= '0;
      byte_vld_o   <= 1'b0;
      byte_o       <= '0;
      addr_phase_o <= 1'b0;
    end else begin
      sclk_d     <= sclk_i;
      mode_d     <= mode_i;
      byte_vld_o <= 1'b0;
      if (mode_chg) begin
        cnt_q <= '0;   // drop partial byte
      end else if (rise) begin
        sr_q  <= {dat_i, sr_q[7:1]};
        cnt_q <= cnt_q + 3'd1;
        if (cnt_q == 3'd7) begin
          byte_vld_o   <= 1'b1;
          byte_o       <= {dat_i, sr_q[7:1]};
          addr_phase_o <= ~mode_i;
        end
      end
    end
  end

  a_r4_vld_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_vld_o |=> !byte_vld_o);
  a_r4_cnt_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rise && !mode_chg) |=> $stable(cnt_q));
endmodule

// File: rtl/ctl3w_chan.sv
module ctl3w_chan
  import ctl3w_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       hit_i,
  input  logic       wr_vol_i,
  input  logic       wr_sub_i,
  input  logic       wr_flg_i,
  input  logic       srst_i,
  input  logic [5:0] wdat_i,
  output chan_t      ch_o
);
  logic [SUB_W-1:0] sub_pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ch_o       <= '{vol: '0, sub: '0, mute: 1'b0, sil: 1'b1, inv: 1'b0};
      sub_pend_q <= '0;
    end else if (srst_i) begin
      ch_o       <= '{vol: '0, sub: '0, mute: 1'b0, sil: 1'b1, inv: 1'b0};
      sub_pend_q <= '0;
    end else if (hit_i) begin
      if (wr_vol_i) begin
        ch_o.vol <= wdat_i[VOL_W-1:0];
        ch_o.sub <= sub_pend_q;
      end
      if (wr_sub_i) sub_pend_q <= wdat_i[SUB_W-1:0];
      if (wr_flg_i) begin
        ch_o.mute <= wdat_i[2];
        ch_o.sil  <= wdat_i[1];
        ch_o.inv  <= wdat_i[0];
      end
    end
  end

  a_r11_sub_on_vol: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ch_o.sub != $past(ch_o.sub)) |-> $past(srst_i || (hit_i && wr_vol_i)));
endmodule

// File: rtl/ctl3w_regs.sv
module ctl3w_regs
  import ctl3w_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 ser_clk_i,
  input  logic                 ser_mode_i,
  input  logic                 ser_dat_i,
  input  logic                 addr_sel_i,
  output logic [1:0]           clk_ratio_o,
  output logic [2:0]           in_fmt_o,
  output logic                 quick_mute_o,
  output logic                 power_on_o,
  output logic [2:0]           deemph_o,
  output logic [NCH*VOL_W-1:0] vol_o,
  output logic [NCH*SUB_W-1:0] sub_vol_o,
  output logic [NCH-1:0]       mute_o,
  output logic [NCH-1:0]       sil_en_o,
  output logic [NCH-1:0]       invert_o
);
  logic [2:0] sync_q;
  logic       byte_vld, addr_ph;
  logic [7:0] rx_byte;

  ctl3w_sync #(.W(3), .STAGES(2)) u_sync (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .d_i   ({ser_clk_i, ser_mode_i, ser_dat_i}),
    .q_o   (sync_q)
  );

  ctl3w_rx u_rx (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .sclk_i (sync_q[2]), .mode_i (sync_q[1]), .dat_i (sync_q[0]),
    .byte_vld_o (byte_vld), .byte_o (rx_byte), .addr_phase_o (addr_ph)
  );

  logic            sel_q, bank_stat_q, ach_q;
  logic [2:0]      chp_q;
  logic            dev_match;
  logic            data_wr, stat_wr;
  logic            wr_vol, wr_sub, wr_flg, wr_chs, st_ctl, st_pwr, srst;
  logic [NCH-1:0]  hit;

  assign dev_match = rx_byte[7:2] == (DEV_BASE | {5'b0, addr_sel_i});
  assign data_wr   = byte_vld & ~addr_ph & sel_q & ~bank_stat_q;
  assign stat_wr   = byte_vld & ~addr_ph & sel_q &  bank_stat_q;
  assign wr_vol    = data_wr & (rx_byte[7:6] == 2'b00);
  assign wr_sub    = data_wr & (rx_byte[7:2] == 6'b010000);
  assign wr_flg    = data_wr & (rx_byte[7:6] == 2'b10);
  assign wr_chs    = data_wr & (rx_byte[7:4] == 4'b1100);
  assign st_ctl    = stat_wr & ~rx_byte[7];
  assign st_pwr    = stat_wr & (rx_byte[7:2] == 6'b100000);
  assign srst      = st_ctl & rx_byte[6];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q        <= 1'b0;
      bank_stat_q  <= 1'b0;
      ach_q        <= 1'b1;
      chp_q        <= '0;
      clk_ratio_o  <= '0;
      in_fmt_o     <= '0;
      quick_mute_o <= 1'b0;
      power_on_o   <= 1'b1;
      deemph_o     <= '0;
    end else begin
      if (byte_vld && addr_ph) begin
        sel_q       <= dev_match & ~rx_byte[0];  // types 01/11 unused
        bank_stat_q <= rx_byte[1];
      end
      if (wr_chs) begin
        ach_q <= rx_byte[3];
        chp_q <= rx_byte[2:0];
      end
      if (wr_flg && ach_q) deemph_o <= rx_byte[5:3];
      if (st_ctl) begin
        clk_ratio_o <= rx_byte[5:4];
        in_fmt_o    <= rx_byte[3:1];
      end
      if (st_pwr) begin
        quick_mute_o <= rx_byte[1];
        power_on_o   <= rx_byte[0];
      end
      if (srst) begin
        quick_mute_o <= 1'b0;
        power_on_o   <= 1'b1;
        deemph_o     <= '0;
      end
    end
  end

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    chan_t ch;
    assign hit[k] = ach_q | (chp_q == 3'(k));
    ctl3w_chan u_ch (
      .clk_i (clk_i), .rst_ni (rst_ni), .hit_i (hit[k]),
      .wr_vol_i (wr_vol), .wr_sub_i (wr_sub), .wr_flg_i (wr_flg),
      .srst_i (srst), .wdat_i (rx_byte[5:0]), .ch_o (ch)
    );
    assign vol_o[k*VOL_W +: VOL_W]     = ch.vol;
    assign sub_vol_o[k*SUB_W +: SUB_W] = ch.sub;
    assign mute_o[k]   = ch.mute;
    assign sil_en_o[k] = ch.sil;
    assign invert_o[k] = ch.inv;
  end

  a_r2_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_q |=> ($stable(vol_o) && $stable(mute_o) && $stable(power_on_o)
                && $stable(clk_ratio_o) && $stable(deemph_o)));
  a_r9_unused_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ach_q && chp_q > 3'd5 && !stat_wr) |=> ($stable(vol_o) && $stable(mute_o)
                && $stable(sil_en_o) && $stable(invert_o)));
  a_r12_keep_ratio: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst |=> (clk_ratio_o == $past(rx_byte[5:4]) && power_on_o));
endmodule

// File: tb/tb_ctl3w_regs.sv
module tb_ctl3w_regs;
  logic clk = 0, rst_n = 0;
  logic sclk = 0, smode = 0, sdat = 0, asel = 0;
  logic [1:0] clk_ratio; logic [2:0] in_fmt, deemph;
  logic qm, pw;
  logic [35:0] vol; logic [11:0] sub;
  logic [5:0] mute, sil, inv;

  always #5 clk = ~clk;

  ctl3w_regs dut (
    .clk_i(clk), .rst_ni(rst_n), .ser_clk_i(sclk), .ser_mode_i(smode),
    .ser_dat_i(sdat), .addr_sel_i(asel), .clk_ratio_o(clk_ratio),
    .in_fmt_o(in_fmt), .quick_mute_o(qm), .power_on_o(pw), .deemph_o(deemph),
    .vol_o(vol), .sub_vol_o(sub), .mute_o(mute), .sil_en_o(sil), .invert_o(inv)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  int ev[6], es[6], ep[6];
  logic [5:0] em, esl, ei;
  int esc, efmt, eqm, epw, ede;

  task automatic chk(string tag, logic [63:0] a, logic [63:0] e);
    n_chk++;
    if (a !== e) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, a, e);
    end
  endtask

  task automatic check_all(string tag);
    logic [35:0] pv; logic [11:0] ps;
    for (int k = 0; k < 6; k++) begin
      pv[k*6 +: 6] = 6'(ev[k]);
      ps[k*2 +: 2] = 2'(es[k]);
    end
    chk({tag, " vol"}, 64'(vol), 64'(pv));
    chk({tag, " sub"}, 64'(sub), 64'(ps));
    chk({tag, " flags"}, {46'b0, mute, sil, inv}, {46'b0, em, esl, ei});
    chk({tag, " global"}, {52'b0, clk_ratio, in_fmt, qm, pw, deemph},
        {52'b0, 2'(esc), 3'(efmt), 1'(eqm), 1'(epw), 3'(ede)});
  endtask

  task automatic defaults();
    for (int k = 0; k < 6; k++) begin ev[k] = 0; es[k] = 0; ep[k] = 0; end
    em = 0; esl = 6'h3f; ei = 0; eqm = 0; epw = 1; ede = 0;
  endtask

  task automatic send_bits(bit m, logic [7:0] b, int n);
    @(negedge clk); smode = m;
    repeat (4) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      sdat = b[i];
      repeat (4) @(negedge clk); sclk = 1;
      repeat (4) @(negedge clk); sclk = 0;
    end
    repeat (8) @(negedge clk);
  endtask

  task automatic addr(logic [7:0] b);  send_bits(0, b, 8); endtask
  task automatic dbyte(logic [7:0] b); send_bits(1, b, 8); endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    esc = 0; efmt = 0; defaults();
    repeat (3) @(negedge clk); rst_n = 1;
    repeat (3) @(negedge clk);
    check_all("R13 reset");

    // R1 R3 R7: broadcast volume sweep on data bank
    addr(8'h10);
    for (int v = 0; v < 64; v++) begin
      dbyte(8'(v));
      for (int k = 0; k < 6; k++) ev[k] = v;
      check_all("R7 R3 vol sweep");
    end

    // R8: individual channel pointer
    for (int c = 0; c < 6; c++) begin
      dbyte(8'hC0 | 8'(c));
      dbyte(8'(10 + c));
      ev[c] = 10 + c;
      check_all("R8 per-channel vol");
    end

    // R9: unused channel codes
    for (int c = 6; c < 8; c++) begin
      dbyte(8'hC0 | 8'(c));
      dbyte(8'h3f);
      dbyte(8'h87);
      check_all("R9 unused code");
    end

    // R11: sub volume pending until volume write
    dbyte(8'hC2);
    dbyte(8'h43); ep[2] = 3;
    check_all("R11 sub pending");
    dbyte(8'h05); ev[2] = 5; es[2] = ep[2];
    check_all("R11 sub applied");

    // R10: flags, de-emphasis ignored without broadcast
    dbyte(8'hC4);
    dbyte(8'h80 | (8'd3 << 3) | 8'b101);
    em[4] = 1; esl[4] = 0; ei[4] = 1;
    check_all("R10 flags single");
    dbyte(8'hC8);
    dbyte(8'h80 | (8'd4 << 3) | 8'b011);
    em = 0; esl = 6'h3f; ei = 6'h3f; ede = 4;
    check_all("R10 flags broadcast");

    // R5 R6: status bank
    addr(8'h12);
    dbyte(8'h00 | (8'd2 << 4) | (8'd5 << 1)); esc = 2; efmt = 5;
    check_all("R5 status ctl");
    dbyte(8'h81); eqm = 0; epw = 1;
    check_all("R6 power byte");
    dbyte(8'h82); eqm = 1; epw = 0;
    check_all("R6 quick mute byte");

    // R2: wrong device code
    addr(8'h18);
    dbyte(8'h00); dbyte(8'h81);
    check_all("R2 deselected");
    // R9: unused bank type
    addr(8'h11);
    dbyte(8'h00); dbyte(8'hC0);
    check_all("R9 unused bank");

    // R1: address select pin
    asel = 1;
    addr(8'h10);
    dbyte(8'h2a);
    check_all("R1 sel mismatch");
    addr(8'h14);
    dbyte(8'h2a); for (int k = 0; k < 6; k++) ev[k] = 42;
    check_all("R1 sel match");

    // R4: partial byte discarded on mode change
    send_bits(1, 8'h3f, 4);
    check_all("R4 partial");
    send_bits(0, 8'h00, 0);
    dbyte(8'h21); for (int k = 0; k < 6; k++) ev[k] = 33;
    check_all("R4 after resync");

    // R12: reset command
    dbyte(8'hC3); dbyte(8'h42); ep[3] = 2;
    addr(8'h16);
    dbyte(8'h40 | (8'd1 << 4) | (8'd2 << 1));
    esc = 1; efmt = 2; defaults();
    check_all("R12 soft reset");
    addr(8'h14);
    dbyte(8'hC3); dbyte(8'h07); ev[3] = 7; es[3] = 0;
    check_all("R12 pending cleared");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule